// File: doc/BRIEF.md
# Privileged Control Register and Exception Unit

This unit holds the privileged machine state of a 32-bit RISC core: the processor status word and its two saved copies (one for exceptions, one for breaks), the interrupt enable mask, a pending-interrupt view, a read-only identification word and the cause of the last exception. Each cycle the core's decode stage presents at most one operation: a control read, a control write, an exception return, a break return, a trap, a break, an undefined opcode, or an ordinary instruction that only gives interrupts a chance to be taken.

The unit decides the outcome in the same cycle. Its outputs are a write request for the general register file (the control-read destination, or the saved return address), a PC redirect, and a resynchronisation pulse. All control state is updated at the next clock edge. The pending value is never stored. It is formed from the external interrupt lines masked by the enable register. An interrupt request is raised from that value together with the status interrupt-enable bit.

Top module: `ctlx_unit`

## Requirements
- R1: After reset, status, estatus, bstatus, ienable and the cause register read as zero. The unit is in supervisor mode (`priv_user` low) and `irq_req` is low whatever the interrupt lines do.
- R2: A control read in supervisor mode writes the indexed register to GPR `op_dst` in the same cycle. The indices are 0 status, 1 estatus, 2 bstatus, 3 ienable, 4 pending, 5 identification (`CPU_ID`) and 7 cause. Any other index reads zero. A read with `op_dst` = 0 writes nothing.
- R3: Reading index 4 returns `irq_lines` ANDed with ienable. Writes to index 4 change nothing.
- R4: A supervisor write to index 0 or 3 raises `resync` in that cycle. Writes to other indices do not. The new value acts on `irq_req` from the next cycle on.
- R5: `irq_req` is high exactly when status bit 0 (interrupt enable) is 1 and the masked pending value is nonzero.
- R6: An exception return in supervisor mode copies estatus into status and redirects to `ea_val`.
- R7: A break return in supervisor mode copies bstatus into status and redirects to `ba_val`.
- R8: With status bit 1 (user) set, a control read, control write, exception return or break return enters the exception path with cause 5. It has no other effect: no register write, no return and no resync.
- R9: Exception entry copies status to estatus and clears status bits 0 and 1. It writes the return address to GPR 29 and redirects to `EXC_VECTOR`. The return address is `insn_pc`+4 for a trap, an undefined opcode or a privilege fault.
- R10: A break copies status to bstatus, clears status bits 0 and 1, writes `insn_pc`+4 to GPR 30 and redirects to `BRK_VECTOR`.
- R11: When `irq_req` is high and `op_valid` is set, the operation is not executed. An interrupt exception is entered instead, with return address `insn_pc`.
- R12: Cause codes, held in bits 4:0 of index 7, are 1 interrupt, 2 trap, 4 undefined opcode and 5 privilege fault. A break leaves the cause unchanged.
- R13: `op_kind` encoding: 0 ordinary, 1 control read, 2 control write, 3 exception return, 4 break return, 5 trap, 6 break, 7 undefined opcode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| op_valid | input | 1 | An operation is presented this cycle |
| op_kind | input | 3 | Operation class (R13) |
| op_idx | input | 5 | Control register index |
| op_dst | input | 5 | Destination GPR of a control read |
| op_wdata | input | XLEN | Source value of a control write |
| insn_pc | input | XLEN | Address of the presented instruction |
| ea_val | input | XLEN | Current content of GPR 29 |
| ba_val | input | XLEN | Current content of GPR 30 |
| irq_lines | input | NIRQ | External interrupt lines |
| gpr_we | output | 1 | Register file write request |
| gpr_idx | output | 5 | Register file write index |
| gpr_data | output | XLEN | Register file write data |
| redir_valid | output | 1 | PC redirect request |
| redir_pc | output | XLEN | Redirect target |
| resync | output | 1 | Re-evaluate interrupts before the next instruction |
| irq_req | output | 1 | Interrupt request |
| priv_user | output | 1 | Status user bit |

## Verification
Corrupted status bits show up at the ports within one operation. A wrong user bit turns the next control access into a fault that redirects to the exception vector. A wrong enable bit either raises `irq_req` on an ordinary instruction or lets a set line pass unnoticed. Wrong saved copies or a wrong cause stay hidden until a later return or control read exposes them, so the stimulus reads each saved register back right after the event that wrote it. It then returns through it, so that a wrong save is seen within two operations.

// File: rtl/ctlx_pkg.sv
package ctlx_pkg;
  localparam int IDX_W   = 5;
  localparam int CAUSE_W = 5;
  localparam int ST_W    = 2;
  localparam int ST_PIE  = 0;
  localparam int ST_USER = 1;

  typedef enum logic [2:0] {
    OP_PLAIN = 3'd0,
    OP_RDCTL = 3'd1,
    OP_WRCTL = 3'd2,
    OP_ERET  = 3'd3,
    OP_BRET  = 3'd4,
    OP_TRAP  = 3'd5,
    OP_BREAK = 3'd6,
    OP_UNDEF = 3'd7
  } op_kind_e;

  localparam logic [IDX_W-1:0] CR_STATUS  = 5'd0;
  localparam logic [IDX_W-1:0] CR_ESTATUS = 5'd1;
  localparam logic [IDX_W-1:0] CR_BSTATUS = 5'd2;
  localparam logic [IDX_W-1:0] CR_IENABLE = 5'd3;
  localparam logic [IDX_W-1:0] CR_PEND    = 5'd4;
  localparam logic [IDX_W-1:0] CR_IDENT   = 5'd5;
  localparam logic [IDX_W-1:0] CR_CAUSE   = 5'd7;

  localparam logic [IDX_W-1:0] GPR_ZERO = 5'd0;
  localparam logic [IDX_W-1:0] GPR_EA   = 5'd29;
  localparam logic [IDX_W-1:0] GPR_BA   = 5'd30;

  localparam logic [CAUSE_W-1:0] CAUSE_IRQ   = 5'd1;
  localparam logic [CAUSE_W-1:0] CAUSE_TRAP  = 5'd2;
  localparam logic [CAUSE_W-1:0] CAUSE_UNDEF = 5'd4;
  localparam logic [CAUSE_W-1:0] CAUSE_PRIV  = 5'd5;

  typedef struct packed {
    logic               enter_exc;
    logic               enter_brk;
    logic               take_irq;
    logic               do_rd;
    logic               do_wr;
    logic               do_eret;
    logic               do_bret;
    logic [CAUSE_W-1:0] cause;
  } act_t;
endpackage

// File: rtl/ctlx_rst_sync.sv
module ctlx_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/ctlx_pend.sv
module ctlx_pend #(
  parameter int NIRQ = 8
) (
  input  logic [NIRQ-1:0] irq_lines,
  input  logic [NIRQ-1:0] ienable,
  input  logic            pie,
  output logic [NIRQ-1:0] pend_masked,
  output logic            irq_req
);
  always_comb begin
    pend_masked = irq_lines & ienable;
    irq_req     = pie && (|pend_masked);
  end
endmodule

// File: rtl/ctlx_decode.sv
module ctlx_decode
  import ctlx_pkg::*;
(
  input  logic              op_valid,
  input  op_kind_e          op_kind,
  input  logic [IDX_W-1:0]  op_dst,
  input  logic              user,
  input  logic              irq_req,
  output act_t              act
);
  logic priv_op, fault, exec;

  always_comb begin
    priv_op = (op_kind == OP_RDCTL) || (op_kind == OP_WRCTL) ||
              (op_kind == OP_ERET)  || (op_kind == OP_BRET);
    fault   = user && priv_op;
    exec    = op_valid && !irq_req;

    act           = '0;
    act.take_irq  = op_valid && irq_req;
    act.enter_exc = act.take_irq ||
                    (exec && (fault || op_kind == OP_TRAP || op_kind == OP_UNDEF));
    act.enter_brk = exec && (op_kind == OP_BREAK);
    act.do_rd     = exec && !fault && (op_kind == OP_RDCTL) && (op_dst != GPR_ZERO);
    act.do_wr     = exec && !fault && (op_kind == OP_WRCTL);
    act.do_eret   = exec && !fault && (op_kind == OP_ERET);
    act.do_bret   = exec && !fault && (op_kind == OP_BRET);

    if (act.take_irq)            act.cause = CAUSE_IRQ;
    else if (fault)              act.cause = CAUSE_PRIV;
    else if (op_kind == OP_TRAP) act.cause = CAUSE_TRAP;
    else                         act.cause = CAUSE_UNDEF;
  end
endmodule

// File: rtl/ctlx_regs.sv
module ctlx_regs
  import ctlx_pkg::*;
#(
  parameter int               XLEN   = 32,
  parameter int               NIRQ   = 8,
  parameter logic [XLEN-1:0]  CPU_ID = 32'h0000_C0DE
) (
  input  logic             clk,
  input  logic             rst_n,
  input  act_t             act,
  input  logic [IDX_W-1:0] op_idx,
  input  logic [XLEN-1:0]  op_wdata,
  input  logic [NIRQ-1:0]  pend_masked,
  output logic [ST_W-1:0]  status,
  output logic [NIRQ-1:0]  ienable,
  output logic [XLEN-1:0]  rd_data
);
  logic [ST_W-1:0]    status_q, status_d, estatus_q, estatus_d, bstatus_q, bstatus_d;
  logic [NIRQ-1:0]    ien_q, ien_d;
  logic [CAUSE_W-1:0] cause_q, cause_d;
  logic               st_en, est_en, bst_en, ien_en, cause_en;
  logic [ST_W-1:0]    cleared;

  // next-state
  always_comb begin
    cleared          = status_q;
    cleared[ST_PIE]  = 1'b0;
    cleared[ST_USER] = 1'b0;

    st_en  = act.enter_exc || act.enter_brk || act.do_eret || act.do_bret ||
             (act.do_wr && op_idx == CR_STATUS);
    if (act.enter_exc || act.enter_brk) status_d = cleared;
    else if (act.do_eret)               status_d = estatus_q;
    else if (act.do_bret)               status_d = bstatus_q;
    else                                status_d = op_wdata[ST_W-1:0];

    est_en    = act.enter_exc || (act.do_wr && op_idx == CR_ESTATUS);
    estatus_d = act.enter_exc ? status_q : op_wdata[ST_W-1:0];

    bst_en    = act.enter_brk || (act.do_wr && op_idx == CR_BSTATUS);
    bstatus_d = act.enter_brk ? status_q : op_wdata[ST_W-1:0];

    ien_en = act.do_wr && (op_idx == CR_IENABLE);
    ien_d  = op_wdata[NIRQ-1:0];

    cause_en = act.enter_exc;
    cause_d  = act.cause;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q  <= '0;
      estatus_q <= '0;
      bstatus_q <= '0;
      ien_q     <= '0;
      cause_q   <= '0;
    end else begin
      if (st_en)    status_q  <= status_d;
      if (est_en)   estatus_q <= estatus_d;
      if (bst_en)   bstatus_q <= bstatus_d;
      if (ien_en)   ien_q     <= ien_d;
      if (cause_en) cause_q   <= cause_d;
    end
  end

  // read mux
  always_comb begin
    case (op_idx)
      CR_STATUS:  rd_data = XLEN'(status_q);
      CR_ESTATUS: rd_data = XLEN'(estatus_q);
      CR_BSTATUS: rd_data = XLEN'(bstatus_q);
      CR_IENABLE: rd_data = XLEN'(ien_q);
      CR_PEND:    rd_data = XLEN'(pend_masked);
      CR_IDENT:   rd_data = CPU_ID;
      CR_CAUSE:   rd_data = XLEN'(cause_q);
      default:    rd_data = '0;
    endcase
  end

  assign status  = status_q;
  assign ienable = ien_q;
endmodule

// File: rtl/ctlx_unit.sv
module ctlx_unit
  import ctlx_pkg::*;
#(
  parameter int              XLEN       = 32,
  parameter int              NIRQ       = 8,
  parameter logic [XLEN-1:0] EXC_VECTOR = 32'h0000_0020,
  parameter logic [XLEN-1:0] BRK_VECTOR = 32'h0000_0100,
  parameter logic [XLEN-1:0] CPU_ID     = 32'h0000_C0DE
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            op_valid,
  input  logic [2:0]      op_kind,
  input  logic [4:0]      op_idx,
  input  logic [4:0]      op_dst,
  input  logic [XLEN-1:0] op_wdata,
  input  logic [XLEN-1:0] insn_pc,
  input  logic [XLEN-1:0] ea_val,
  input  logic [XLEN-1:0] ba_val,
  input  logic [NIRQ-1:0] irq_lines,
  output logic            gpr_we,
  output logic [4:0]      gpr_idx,
  output logic [XLEN-1:0] gpr_data,
  output logic            redir_valid,
  output logic [XLEN-1:0] redir_pc,
  output logic            resync,
  output logic            irq_req,
  output logic            priv_user
);
  logic            rst_sync_n;
  act_t            act;
  logic [ST_W-1:0] status;
  logic [NIRQ-1:0] ienable, pend_masked;
  logic [XLEN-1:0] rd_data, ret_addr;

  ctlx_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  ctlx_pend #(.NIRQ(NIRQ)) u_pend (
    .irq_lines   (irq_lines),
    .ienable     (ienable),
    .pie         (status[ST_PIE]),
    .pend_masked (pend_masked),
    .irq_req     (irq_req)
  );

  ctlx_decode u_dec (
    .op_valid (op_valid),
    .op_kind  (op_kind_e'(op_kind)),
    .op_dst   (op_dst),
    .user     (status[ST_USER]),
    .irq_req  (irq_req),
    .act      (act)
  );

  ctlx_regs #(.XLEN(XLEN), .NIRQ(NIRQ), .CPU_ID(CPU_ID)) u_regs (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .act         (act),
    .op_idx      (op_idx),
    .op_wdata    (op_wdata),
    .pend_masked (pend_masked),
    .status      (status),
    .ienable     (ienable),
    .rd_data     (rd_data)
  );

  always_comb begin
    ret_addr = act.take_irq ? insn_pc : insn_pc + XLEN'(4);

    gpr_we = act.do_rd || act.enter_exc || act.enter_brk;
    if (act.do_rd)          gpr_idx = op_dst;
    else if (act.enter_brk) gpr_idx = GPR_BA;
    else                    gpr_idx = GPR_EA;
    gpr_data = act.do_rd ? rd_data : ret_addr;

    redir_valid = act.enter_exc || act.enter_brk || act.do_eret || act.do_bret;
    if (act.enter_exc)      redir_pc = EXC_VECTOR;
    else if (act.enter_brk) redir_pc = BRK_VECTOR;
    else if (act.do_eret)   redir_pc = ea_val;
    else                    redir_pc = ba_val;

    resync    = act.do_wr && (op_idx == CR_STATUS || op_idx == CR_IENABLE);
    priv_user = status[ST_USER];
  end
endmodule

// File: rtl/ctlx_unit_chk.sv
module ctlx_unit_chk #(
  parameter int              XLEN       = 32,
  parameter int              NIRQ       = 8,
  parameter logic [XLEN-1:0] EXC_VECTOR = 32'h0000_0020,
  parameter logic [XLEN-1:0] BRK_VECTOR = 32'h0000_0100
) (
  input logic            clk,
  input logic            rst_n,
  input logic            op_valid,
  input logic [2:0]      op_kind,
  input logic [4:0]      op_dst,
  input logic [XLEN-1:0] insn_pc,
  input logic [XLEN-1:0] ea_val,
  input logic [XLEN-1:0] ba_val,
  input logic [NIRQ-1:0] irq_lines,
  input logic            gpr_we,
  input logic [4:0]      gpr_idx,
  input logic [XLEN-1:0] gpr_data,
  input logic            redir_valid,
  input logic [XLEN-1:0] redir_pc,
  input logic            resync,
  input logic            irq_req,
  input logic            priv_user
);
  logic sup_ok;
  assign sup_ok = op_valid && !irq_req && !priv_user;

  p_rdzero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    sup_ok && op_kind == 3'd1 && op_dst == 5'd0 |-> !gpr_we);

  p_resync_r4: assert property (@(posedge clk) disable iff (!rst_n)
    resync |-> op_valid && op_kind == 3'd2 && !priv_user && !irq_req);

  p_irqsrc_r5: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> (|irq_lines));

  p_eret_r6: assert property (@(posedge clk) disable iff (!rst_n)
    sup_ok && op_kind == 3'd3 |-> redir_valid && redir_pc == ea_val && !gpr_we);

  p_bret_r7: assert property (@(posedge clk) disable iff (!rst_n)
    sup_ok && op_kind == 3'd4 |-> redir_valid && redir_pc == ba_val && !gpr_we);

  p_priv_r8: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && !irq_req && priv_user && op_kind >= 3'd1 && op_kind <= 3'd4
    |-> redir_valid && redir_pc == EXC_VECTOR && gpr_idx == 5'd29 && !resync);

  p_trap_r9: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && op_kind == 3'd5 |=> !priv_user);

  p_brk_r10: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && !irq_req && op_kind == 3'd6
    |-> redir_pc == BRK_VECTOR && gpr_idx == 5'd30 && gpr_data == insn_pc + XLEN'(4));

  p_irq_r11: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && irq_req |-> redir_valid && redir_pc == EXC_VECTOR && gpr_data == insn_pc);
endmodule

bind ctlx_unit ctlx_unit_chk #(
  .XLEN(XLEN), .NIRQ(NIRQ), .EXC_VECTOR(EXC_VECTOR), .BRK_VECTOR(BRK_VECTOR)
) u_chk (
  .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_kind(op_kind),
  .op_dst(op_dst), .insn_pc(insn_pc), .ea_val(ea_val), .ba_val(ba_val),
  .irq_lines(irq_lines), .gpr_we(gpr_we), .gpr_idx(gpr_idx),
  .gpr_data(gpr_data), .redir_valid(redir_valid), .redir_pc(redir_pc),
  .resync(resync), .irq_req(irq_req), .priv_user(priv_user)
);

// File: tb/sim_ctlx_unit.sv
module sim_ctlx_unit;
  localparam int NV = 37;

  logic        clk, rst_n, op_valid;
  logic [2:0]  op_kind;
  logic [4:0]  op_idx, op_dst;
  logic [31:0] op_wdata, insn_pc, ea_val, ba_val;
  logic [7:0]  irq_lines;
  logic        gpr_we, redir_valid, resync, irq_req, priv_user;
  logic [4:0]  gpr_idx;
  logic [31:0] gpr_data, redir_pc;
  int          checks, errors;

  typedef struct packed {
    logic [7:0]  req;
    logic [2:0]  kind;
    logic [4:0]  idx;
    logic [4:0]  dst;
    logic [31:0] wdata;
    logic [7:0]  irq;
    logic [31:0] pc;
    logic        e_we;
    logic [4:0]  e_gidx;
    logic [31:0] e_gdata;
    logic        e_rv;
    logic [31:0] e_rpc;
    logic        e_rs;
    logic        e_irq;
  } vec_t;

  // kinds (R13): 0 plain 1 rd 2 wr 3 eret 4 bret 5 trap 6 break 7 undef
  localparam vec_t TBL [NV] = '{
    '{8'd2, 3'd1, 5'd0,  5'd5,  32'h0,  8'h00, 32'h0,   1'b1, 5'd5,  32'h0,    1'b0, 32'h0,    1'b0, 1'b0}, // R2 status
    '{8'd4, 3'd2, 5'd3,  5'd0,  32'hFF, 8'h00, 32'h0,   1'b0, 5'd0,  32'h0,    1'b0, 32'h0,    1'b1, 1'b0}, // R4 ienable
    '{8'd2, 3'd1, 5'd3,  5'd6,  32'h0,  8'h00, 32'h0,   1'b1, 5'd6,  32'hFF,   1'b0, 32'h0,    1'b0, 1'b0},
    '{8'd3, 3'd1, 5'd4,  5'd7,  32'h0,  8'h5A, 32'h0,   1'b1, 5'd7,  32'h5A,   1'b0, 32'h0,    1'b0, 1'b0}, // R3
    '{8'd3, 3'd2, 5'd4,  5'd0,  32'h3,  8'h00, 32'h0,   1'b0, 5'd0,  32'h0,    1'b0, 32'h0,    1'b0, 1'b0},
    '{8'd3, 3'd1, 5'd4,  5'd7,  32'h0,  8'h81, 32'h0,   1'b1, 5'd7,  32'h81,   1'b0, 32'h0,    1'b0, 1'b0},
    '{8'd4, 3'd2, 5'd3,  5'd0,  32'h0F, 8'h00, 32'h0,   1'b0, 5'd0,  32'h0,    1'b0, 32'h0,    1'b1, 1'b0},
    '{8'd3, 3'd1, 5'd4,  5'd7,  32'h0,  8'hF3, 32'h0,   1'b1, 5'd7,  32'h03,   1'b0, 32'h0,    1'b0, 1'b0},
    '{8'd2, 3'd1, 5'd0,  5'd0,  32'h0,  8'h00, 32'h0,   1'b0, 5'd0,  32'h0,    1'b0, 32'h0,    1'b0, 1'b0}, // R2 dst 0
    '{8'd4, 3'd2, 5'd1,  5'd0,  32'h3,  8'h00, 32'h0,   1'b0, 5'd0,  32'h0,    1'b0, 32'h0,    1'b0, 1'b0},
    '{8'd4, 3'd2, 5'd2,  5'd0,  32'h2,  8'h00, 32'h0,   1'b0, 5'd0,  32'h0,    1'b0, 32'h0,    1'b0, 1'b0},
    '{8'd2, 3'd1, 5'd1,  5'd8,  32'h0,  8'h00, 32'h0,   1'b1, 5'd8,  32'h3,    1'b0, 32'h0,    1'b0, 1'b0},
    '{8'd9, 3'd5, 5'd0,  5'd0,  32'h0,  8'h00, 32'h500, 1'b1, 5'd29, 32'h504,  1'b1, 32'h20,   1'b0, 1'b0}, // R9 trap
    '{8'd12,3'd1, 5'd7,  5'd9,  32'h0,  8'h00, 32'h0,   1'b1, 5'd9,  32'h2,    1'b0, 32'h0,    1'b0, 1'b0}, // R12
    '{8'd9, 3'd1, 5'd1,  5'd9,  32'h0,  8'h00, 32'h0,   1'b1, 5'd9,  32'h0,    1'b0, 32'h0,    1'b0, 1'b0},
    '{8'd6, 3'd2, 5'd1,  5'd0,  32'h3,  8'h00, 32'h0,   1'b0, 5'd0,  32'h0,    1'b0, 32'h0,    1'b0, 1'b0},
    '{8'd6, 3'd3, 5'd0,  5'd0,  32'h0,  8'h00, 32'h0,   1'b0, 5'd0,  32'h0,    1'b1, 32'h1000, 1'b0, 1'b0}, // R6
    '{8'd8, 3'd1, 5'd0,  5'd10, 32'h0,  8'h00, 32'h600, 1'b1, 5'd29, 32'h604,  1'b1, 32'h20,   1'b0, 1'b0}, // R8
    '{8'd12,3'd1, 5'd7,  5'd9,  32'h0,  8'h00, 32'h0,   1'b1, 5'd9,  32'h5,    1'b0, 32'h0,    1'b0, 1'b0},
    '{8'd8, 3'd1, 5'd1,  5'd9,  32'h0,  8'h00, 32'h0,   1'b1, 5'd9,  32'h3,    1'b0, 32'h0,    1'b0, 1'b0},
    '{8'd4, 3'd2, 5'd0,  5'd0,  32'h1,  8'h00, 32'h0,   1'b0, 5'd0,  32'h0,    1'b0, 32'h0,    1'b1, 1'b0},
    '{8'd5, 3'd0, 5'd0,  5'd0,  32'h0,  8'h10, 32'h0,   1'b0, 5'd0,  32'h0,    1'b0, 32'h0,    1'b0, 1'b0}, // R5 masked
    '{8'd11,3'd0, 5'd0,  5'd0,  32'h0,  8'h02, 32'h650, 1'b1, 5'd29, 32'h650,  1'b1, 32'h20,   1'b0, 1'b1}, // R11
    '{8'd12,3'd1, 5'd7,  5'd9,  32'h0,  8'h02, 32'h0,   1'b1, 5'd9,  32'h1,    1'b0, 32'h0,    1'b0, 1'b0},
    '{8'd10,3'd6, 5'd0,  5'd0,  32'h0,  8'h00, 32'h700, 1'b1, 5'd30, 32'h704,  1'b1, 32'h100,  1'b0, 1'b0}, // R10
    '{8'd10,3'd1, 5'd2,  5'd4,  32'h0,  8'h00, 32'h0,   1'b1, 5'd4,  32'h0,    1'b0, 32'h0,    1'b0, 1'b0},
    '{8'd7, 3'd2, 5'd2,  5'd0,  32'h1,  8'h00, 32'h0,   1'b0, 5'd0,  32'h0,    1'b0, 32'h0,    1'b0, 1'b0},
    '{8'd7, 3'd4, 5'd0,  5'd0,  32'h0,  8'h00, 32'h0,   1'b0, 5'd0,  32'h0,    1'b1, 32'h2000, 1'b0, 1'b0}, // R7
    '{8'd7, 3'd1, 5'd0,  5'd3,  32'h0,  8'h00, 32'h0,   1'b1, 5'd3,  32'h1,    1'b0, 32'h0,    1'b0, 1'b0},
    '{8'd9, 3'd7, 5'd0,  5'd0,  32'h0,  8'h00, 32'h800, 1'b1, 5'd29, 32'h804,  1'b1, 32'h20,   1'b0, 1'b0}, // R9 undef
    '{8'd12,3'd1, 5'd7,  5'd9,  32'h0,  8'h00, 32'h0,   1'b1, 5'd9,  32'h4,    1'b0, 32'h0,    1'b0, 1'b0},
    '{8'd2, 3'd1, 5'd5,  5'd9,  32'h0,  8'h00, 32'h0,   1'b1, 5'd9,  32'hC0DE, 1'b0, 32'h0,    1'b0, 1'b0},
    '{8'd4, 3'd2, 5'd0,  5'd0,  32'h2,  8'h00, 32'h0,   1'b0, 5'd0,  32'h0,    1'b0, 32'h0,    1'b1, 1'b0},
    '{8'd8, 3'd2, 5'd3,  5'd0,  32'hAA, 8'h00, 32'h900, 1'b1, 5'd29, 32'h904,  1'b1, 32'h20,   1'b0, 1'b0},
    '{8'd8, 3'd1, 5'd3,  5'd11, 32'h0,  8'h00, 32'h0,   1'b1, 5'd11, 32'h0F,   1'b0, 32'h0,    1'b0, 1'b0},
    '{8'd2, 3'd1, 5'd6,  5'd12, 32'h0,  8'h00, 32'h0,   1'b1, 5'd12, 32'h0,    1'b0, 32'h0,    1'b0, 1'b0},
    '{8'd2, 3'd1, 5'd20, 5'd12, 32'h0,  8'h00, 32'h0,   1'b1, 5'd12, 32'h0,    1'b0, 32'h0,    1'b0, 1'b0}
  };

  ctlx_unit u0 (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_kind(op_kind),
    .op_idx(op_idx), .op_dst(op_dst), .op_wdata(op_wdata), .insn_pc(insn_pc),
    .ea_val(ea_val), .ba_val(ba_val), .irq_lines(irq_lines),
    .gpr_we(gpr_we), .gpr_idx(gpr_idx), .gpr_data(gpr_data),
    .redir_valid(redir_valid), .redir_pc(redir_pc), .resync(resync),
    .irq_req(irq_req), .priv_user(priv_user)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic expect1(input int req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic idle();
    op_valid = 1'b0; op_kind = 3'd0; op_idx = 5'd0; op_dst = 5'd0;
    op_wdata = 32'h0; insn_pc = 32'h0;
  endtask

  task automatic run_vec(input int n);
    vec_t v;
    logic ok;
    v = TBL[n];
    @(negedge clk);
    op_valid = 1'b1; op_kind = v.kind; op_idx = v.idx; op_dst = v.dst;
    op_wdata = v.wdata; irq_lines = v.irq; insn_pc = v.pc;
    #1;
    checks++;
    ok = (gpr_we === v.e_we) && (redir_valid === v.e_rv) &&
         (resync === v.e_rs) && (irq_req === v.e_irq);
    if (v.e_we) ok = ok && (gpr_idx === v.e_gidx) && (gpr_data === v.e_gdata);
    if (v.e_rv) ok = ok && (redir_pc === v.e_rpc);
    if (!ok) begin
      errors++;
      $display("FAIL R%0d vec %0d: we/idx/data=%b/%0d/%h exp %b/%0d/%h redir=%b/%h exp %b/%h rs=%b exp %b irq=%b exp %b",
               v.req, n, gpr_we, gpr_idx, gpr_data, v.e_we, v.e_gidx, v.e_gdata,
               redir_valid, redir_pc, v.e_rv, v.e_rpc, resync, v.e_rs, irq_req, v.e_irq);
    end
  endtask

  initial begin
    #100000;
    errors++;
    $display("FAIL R1 watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    checks = 0; errors = 0;
    rst_n = 1'b0; ea_val = 32'h1000; ba_val = 32'h2000; irq_lines = 8'hFF;
    idle();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    #1;
    // R1 reset state
    expect1(1, "irq_req after reset", {31'b0, irq_req}, 32'h0);
    expect1(1, "priv_user after reset", {31'b0, priv_user}, 32'h0);
    expect1(1, "no action while idle", {30'b0, gpr_we, redir_valid}, 32'h0);
    irq_lines = 8'h00;

    for (int i = 0; i < NV; i++) run_vec(i);

    // R1 reset mid-run clears ienable and status
    @(negedge clk);
    idle();
    irq_lines = 8'h00;
    op_valid = 1'b1; op_kind = 3'd2; op_idx = 5'd0; op_wdata = 32'h1;
    @(negedge clk);
    idle();
    irq_lines = 8'hFF;
    #1;
    expect1(5, "irq_req with pie set", {31'b0, irq_req}, 32'h1);
    rst_n = 1'b0;
    #1;
    expect1(1, "irq_req during reset", {31'b0, irq_req}, 32'h0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    op_valid = 1'b1; op_kind = 3'd1; op_idx = 5'd3; op_dst = 5'd2;
    #1;
    expect1(1, "ienable after reset", gpr_data, 32'h0);
    @(negedge clk);
    op_idx = 5'd7;
    #1;
    expect1(1, "cause after reset", gpr_data, 32'h0);
    @(negedge clk);
    op_idx = 5'd1;
    #1;
    expect1(1, "estatus after reset", gpr_data, 32'h0);
    @(negedge clk);
    idle();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule